// File: doc/BRIEF.md
# Reservation Monitor for Linked Load and Conditional Store

This block sits on one core's path to memory and gives that core an atomic read-modify-write built from two operations. A linked load reads memory like any load and leaves behind a reservation on the physical cache line it touched. A later conditional store reaches memory only if that reservation is still standing. The reservation is one valid flag and one line tag. Several things clear it: a write-invalidate snooped from another agent that hits the line, a trap taken by the local core, the local cache evicting the line, or any conditional store.

The reservation tracks events, not data. A write that puts back the old value still breaks it, and so does a write to another word of the same 64-byte line, whether it comes from another core or from a DMA engine. Each conditional store gets a one-bit verdict, marked by a strobe one cycle after the store is accepted. The verdict, the addresses and the store data all come from the same accept cycle, so the decision needs no extra pipeline stage.

Requests from the core arrive on a valid/ready channel. The rules for back-pressure are these:
- The core holds `core_valid`, `core_op`, `core_addr` and `core_wdata` steady until `core_ready` is high at a clock edge.
- A request that goes on to memory is accepted in the cycle that memory takes it, so `core_ready` follows `mem_ready`.
- A conditional store that will fail is accepted at once and never reaches memory. While it waits, a pending conditional store can therefore drop `mem_valid` if its reservation breaks.
- Read data returns from memory to the core on a path outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: The `core_op` code is 0 for load, 1 for store, 2 for linked load and 3 for conditional store. A linked load (2) goes to memory as a read. When it is accepted, the reservation becomes valid and holds the line address (`core_addr` with its low 6 bits dropped).
- R2: A conditional store (3) issues a memory write only if the reservation is valid and its line equals the line of `core_addr`. Otherwise there is no memory request at all, the store is accepted in the same cycle, and memory is untouched. This means that a different physical line fails.
- R3: `sc_rsp_valid` is high for exactly one cycle, in the cycle after a conditional store is accepted, and at no other time. With it, `sc_rsp_ok` is 1 if the write was issued and 0 if it was not.
- R4: A snooped write-invalidate (`snoop_valid`) whose line equals the reserved line clears the reservation.
- R5: All matching uses 64-byte lines. A snoop to any of the 64 byte offsets of the reserved line breaks the reservation, while a snoop to the next or the previous line leaves it standing. A conditional store to any offset within the reserved line passes.
- R6: `trap_taken` clears the reservation, whatever address is involved.
- R7: `evict_valid` with the reserved line clears the reservation. An eviction of any other line has no effect on it.
- R8: Every accepted conditional store clears the reservation, whether it passes or fails, so a second store with no new linked load fails.
- R9: A clearing event (a hitting snoop, a trap, or a hitting eviction) in the same cycle as a conditional store beats the store. The store fails and issues no write.
- R10: A new linked load replaces any earlier reservation. If a linked load is accepted in the same cycle as a trap, or as a snoop or eviction to its own line, it leaves no valid reservation.
- R11: Plain loads (0) and stores (1), including ones to the reserved line, neither set nor clear the reservation.
- R12: Any request other than a failing conditional store is passed to memory with the same address and data, and `core_ready` equals `mem_ready` while it waits.
- R13: After reset there is no reservation and no response strobe. A conditional store issued first after reset fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request valid |
| core_ready | output | 1 | Core request accepted this cycle |
| core_op | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| core_addr | input | PA_W | Physical byte address |
| core_wdata | input | DATA_W | Store data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory takes request |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | PA_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| snoop_valid | input | 1 | Write-invalidate seen from another agent |
| snoop_addr | input | PA_W | Snooped address |
| trap_taken | input | 1 | Local exception or interrupt taken |
| evict_valid | input | 1 | Local cache evicts a line |
| evict_addr | input | PA_W | Evicted address |
| sc_rsp_valid | output | 1 | Conditional-store verdict strobe |
| sc_rsp_ok | output | 1 | 1 pass, 0 fail |

## Verification
A reservation that is wrongly left valid shows up at the very next conditional store, as a memory write plus `sc_rsp_ok` = 1 where the model expects silence. A reservation that is lost or holds the wrong tag shows up one cycle after a store that should have passed, as a 0 verdict with no write. The sweeps cover every byte offset of the reserved line and its two neighbours for snoops, and offsets within the line for stores. They also pair each clearing event with a store or linked load in the same cycle, so that an error in line masking or in priority appears at the first affected request.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } llsc_op_e;

  localparam int unsigned CMP_CORE  = 0;
  localparam int unsigned CMP_SNOOP = 1;
  localparam int unsigned CMP_EVICT = 2;
  localparam int unsigned CMP_NUM   = 3;

endpackage

// File: rtl/llsc_line_cmp.sv
module llsc_line_cmp #(
  parameter int unsigned TAG_W = 26
) (
  input  logic             en,
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  output logic             hit
);
  assign hit = en && (tag_a == tag_b);
endmodule

// File: rtl/llsc_resv_state.sv
module llsc_resv_state #(
  parameter int unsigned TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  output logic             resv_valid,
  output logic [TAG_W-1:0] resv_tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_tag   <= '0;
    end else if (clr_en) begin
      resv_valid <= 1'b0;
    end else if (set_en) begin
      resv_valid <= 1'b1;
      resv_tag   <= set_tag;
    end
  end
endmodule

// File: rtl/llsc_sc_resp.sv
module llsc_sc_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_fire,
  input  logic cond_pass,
  output logic rsp_valid,
  output logic rsp_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= cond_fire;
      rsp_ok    <= cond_fire && cond_pass;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int unsigned PA_W       = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic [1:0]        core_op,
  input  logic [PA_W-1:0]   core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [PA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              snoop_valid,
  input  logic [PA_W-1:0]   snoop_addr,
  input  logic              trap_taken,
  input  logic              evict_valid,
  input  logic [PA_W-1:0]   evict_addr,
  output logic              sc_rsp_valid,
  output logic              sc_rsp_ok
);
  import llsc_pkg::*;

  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W = PA_W - OFF_W;

  llsc_op_e         op;
  logic             is_link, is_cond, is_store;
  logic [TAG_W-1:0] core_tag, snoop_tag, evict_tag, ref_tag;
  logic             resv_valid;
  logic [TAG_W-1:0] resv_tag;
  logic             link_fire, cond_fire, fire;
  logic             kill, cond_pass, cond_drop;
  logic             set_en, clr_en;

  logic [CMP_NUM-1:0]             cmp_en;
  logic [CMP_NUM-1:0][TAG_W-1:0]  cmp_a;
  logic [CMP_NUM-1:0][TAG_W-1:0]  cmp_b;
  logic [CMP_NUM-1:0]             cmp_hit;

  assign op        = llsc_op_e'(core_op);
  assign is_link   = (op == OP_LINK);
  assign is_cond   = (op == OP_COND);
  assign is_store  = (op == OP_STORE);
  assign core_tag  = core_addr[PA_W-1:OFF_W];
  assign snoop_tag = snoop_addr[PA_W-1:OFF_W];
  assign evict_tag = evict_addr[PA_W-1:OFF_W];

  // A linked load accepted this cycle is the line that events must be checked against.
  assign link_fire = core_valid && is_link && mem_ready;
  assign ref_tag   = link_fire ? core_tag : resv_tag;

  assign cmp_en[CMP_CORE]  = resv_valid;
  assign cmp_a[CMP_CORE]   = core_tag;
  assign cmp_b[CMP_CORE]   = resv_tag;
  assign cmp_en[CMP_SNOOP] = snoop_valid;
  assign cmp_a[CMP_SNOOP]  = snoop_tag;
  assign cmp_b[CMP_SNOOP]  = ref_tag;
  assign cmp_en[CMP_EVICT] = evict_valid;
  assign cmp_a[CMP_EVICT]  = evict_tag;
  assign cmp_b[CMP_EVICT]  = ref_tag;

  for (genvar gi = 0; gi < CMP_NUM; gi++) begin : g_cmp
    llsc_line_cmp #(.TAG_W(TAG_W)) u_cmp (
      .en    (cmp_en[gi]),
      .tag_a (cmp_a[gi]),
      .tag_b (cmp_b[gi]),
      .hit   (cmp_hit[gi])
    );
  end

  assign kill      = cmp_hit[CMP_SNOOP] || cmp_hit[CMP_EVICT] || trap_taken;
  assign cond_pass = is_cond && cmp_hit[CMP_CORE] && !kill;
  assign cond_drop = is_cond && !cond_pass;

  assign mem_valid  = core_valid && !cond_drop;
  assign mem_write  = is_store || is_cond;
  assign mem_addr   = core_addr;
  assign mem_wdata  = core_wdata;
  assign core_ready = cond_drop ? 1'b1 : mem_ready;

  assign fire      = core_valid && core_ready;
  assign cond_fire = fire && is_cond;
  assign set_en    = link_fire && !kill;
  assign clr_en    = kill || cond_fire;

  llsc_resv_state #(.TAG_W(TAG_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (set_en),
    .set_tag    (core_tag),
    .clr_en     (clr_en),
    .resv_valid (resv_valid),
    .resv_tag   (resv_tag)
  );

  llsc_sc_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_fire (cond_fire),
    .cond_pass (cond_pass),
    .rsp_valid (sc_rsp_valid),
    .rsp_ok    (sc_rsp_ok)
  );

  a_r1_link_reserves: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_ready && core_op == 2'd2 && !trap_taken
     && !(snoop_valid && snoop_addr[PA_W-1:OFF_W] == core_addr[PA_W-1:OFF_W])
     && !(evict_valid && evict_addr[PA_W-1:OFF_W] == core_addr[PA_W-1:OFF_W]))
    |=> (resv_valid && resv_tag == $past(core_addr[PA_W-1:OFF_W])));

  a_r2_write_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_op == 2'd3 && mem_valid)
    |-> (resv_valid && resv_tag == core_addr[PA_W-1:OFF_W]));

  a_r3_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_ready && core_op == 2'd3) |=> sc_rsp_valid);

  a_r3_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_valid && core_ready && core_op == 2'd3) |=> !sc_rsp_valid);

  a_r3_fail_had_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_rsp_valid && !sc_rsp_ok) |-> $past(!mem_valid));

  a_r4_snoop_breaks: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && resv_valid && snoop_addr[PA_W-1:OFF_W] == resv_tag
     && !(core_valid && core_ready && core_op == 2'd2))
    |=> !resv_valid);

  a_r6_trap_breaks: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> !resv_valid);

  a_r8_cond_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_ready && core_op == 2'd3) |=> !resv_valid);

endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_valid = 1'b0;
  logic        core_ready;
  logic [1:0]  core_op = 2'd0;
  logic [31:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        trap_taken = 1'b0;
  logic        evict_valid = 1'b0;
  logic [31:0] evict_addr = '0;
  logic        sc_rsp_valid;
  logic        sc_rsp_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the reservation, from the requirements
  bit          m_valid = 1'b0;
  logic [25:0] m_line = '0;

  always #2 clk = ~clk;

  llsc_monitor u_llsc_monitor (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
    .core_addr(core_addr), .core_wdata(core_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .trap_taken(trap_taken), .evict_valid(evict_valid), .evict_addr(evict_addr),
    .sc_rsp_valid(sc_rsp_valid), .sc_rsp_ok(sc_rsp_ok)
  );

  function automatic logic [25:0] ln(input logic [31:0] a);
    return a[31:6];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [31:0] addr, input string req,
                        input int stall = 0,
                        input bit snp = 0, input logic [31:0] saddr = '0,
                        input bit trp = 0,
                        input bit ev = 0, input logic [31:0] eaddr = '0);
    bit exp_pass;
    bit wrote;
    bit acc;
    int k;
    exp_pass = m_valid && ln(addr) == m_line && !trp
               && !(snp && ln(saddr) == m_line) && !(ev && ln(eaddr) == m_line);
    @(negedge clk);
    core_valid = 1'b1; core_op = op; core_addr = addr; core_wdata = addr ^ 32'h5a5a_0f0f;
    snoop_valid = snp; snoop_addr = saddr; trap_taken = trp;
    evict_valid = ev; evict_addr = eaddr;
    k = 0; wrote = 1'b0;
    forever begin
      mem_ready = (k >= stall);
      #1;
      acc = core_ready;
      if (mem_valid && mem_ready && mem_write) wrote = 1'b1;
      if (k < stall) begin
        // R12: request waits while memory stalls, unless it is a failing store
        chk("R12", "core_ready during stall", {31'd0, acc},
            {31'd0, (op == 2'd3 && !exp_pass)});
        if (op != 2'd3 || exp_pass)
          chk("R12", "mem_addr forwarded", mem_addr, addr);
      end
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
      snoop_valid = 1'b0; trap_taken = 1'b0; evict_valid = 1'b0;
      k++;
    end
    @(negedge clk);
    core_valid = 1'b0; snoop_valid = 1'b0; trap_taken = 1'b0; evict_valid = 1'b0;
    mem_ready = 1'b1;
    #1;
    if (op == 2'd3) begin
      chk("R3", "sc_rsp_valid after store", {31'd0, sc_rsp_valid}, 32'd1);
      chk(req, "sc_rsp_ok", {31'd0, sc_rsp_ok}, {31'd0, exp_pass});
      chk("R2", "write issued", {31'd0, wrote}, {31'd0, exp_pass});
      m_valid = 1'b0;
    end else begin
      chk("R3", "no strobe for other ops", {31'd0, sc_rsp_valid}, 32'd0);
      if (op == 2'd1) chk("R12", "store wrote", {31'd0, wrote}, 32'd1);
      if (op == 2'd2) begin
        m_valid = !(trp || (snp && ln(saddr) == ln(addr)) || (ev && ln(eaddr) == ln(addr)));
        m_line  = ln(addr);
      end else begin
        if (trp) m_valid = 1'b0;
        if (snp && ln(saddr) == m_line) m_valid = 1'b0;
        if (ev && ln(eaddr) == m_line) m_valid = 1'b0;
      end
    end
  endtask

  task automatic pulse(input bit snp, input logic [31:0] saddr, input bit trp,
                       input bit ev, input logic [31:0] eaddr);
    @(negedge clk);
    snoop_valid = snp; snoop_addr = saddr; trap_taken = trp;
    evict_valid = ev; evict_addr = eaddr;
    @(negedge clk);
    snoop_valid = 1'b0; trap_taken = 1'b0; evict_valid = 1'b0;
    if (trp) m_valid = 1'b0;
    if (snp && ln(saddr) == m_line) m_valid = 1'b0;
    if (ev && ln(eaddr) == m_line) m_valid = 1'b0;
  endtask

  localparam logic [31:0] BASE_A = 32'h0000_4000;
  localparam logic [31:0] BASE_B = 32'h0000_9A40;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R13 reset state
    chk("R13", "sc_rsp_valid after reset", {31'd0, sc_rsp_valid}, 32'd0);
    chk("R13", "mem_valid idle", {31'd0, mem_valid}, 32'd0);
    do_req(2'd3, BASE_A, "R13");

    // R1 / R2 basic pair, with memory back-pressure
    do_req(2'd2, BASE_A, "R1", 2);
    do_req(2'd3, BASE_A + 32'd8, "R1", 3);
    // R8 second store without new link fails
    do_req(2'd3, BASE_A, "R8");
    // R8 failed store also consumes
    do_req(2'd2, BASE_A, "R1");
    do_req(2'd3, BASE_B, "R2");
    do_req(2'd3, BASE_A, "R8");

    // R4 / R5 snoop offset sweep over reserved line and both neighbours
    for (int off = 0; off < 64; off++) begin
      do_req(2'd2, BASE_A + 32'd4, "R1");
      pulse(1'b1, BASE_A + off, 1'b0, 1'b0, '0);
      do_req(2'd3, BASE_A + 32'd4, "R4");
      do_req(2'd2, BASE_A + 32'd4, "R1");
      pulse(1'b1, BASE_A + 32'd64 + off, 1'b0, 1'b0, '0);
      pulse(1'b1, BASE_A - 32'd64 + off, 1'b0, 1'b0, '0);
      do_req(2'd3, BASE_A + 32'd4, "R5");
    end

    // R5 store offsets within the line
    for (int off = 0; off < 64; off += 7) begin
      do_req(2'd2, BASE_B + 32'd5, "R1");
      do_req(2'd3, BASE_B + off, "R5");
    end
    do_req(2'd2, BASE_B, "R1");
    do_req(2'd3, BASE_B + 32'd64, "R2");

    // R6 trap, separate and same cycle
    do_req(2'd2, BASE_A, "R1");
    pulse(1'b0, '0, 1'b1, 1'b0, '0);
    do_req(2'd3, BASE_A, "R6");
    do_req(2'd2, BASE_A, "R1");
    do_req(2'd3, BASE_A, "R9", 0, 1'b0, '0, 1'b1);

    // R7 eviction of own and other line
    do_req(2'd2, BASE_A, "R1");
    pulse(1'b0, '0, 1'b0, 1'b1, BASE_A + 32'd60);
    do_req(2'd3, BASE_A, "R7");
    do_req(2'd2, BASE_A, "R1");
    pulse(1'b0, '0, 1'b0, 1'b1, BASE_B);
    do_req(2'd3, BASE_A, "R7");

    // R9 same-cycle snoop / eviction against store
    do_req(2'd2, BASE_A, "R1");
    do_req(2'd3, BASE_A, "R9", 0, 1'b1, BASE_A + 32'd33);
    do_req(2'd2, BASE_A, "R1");
    do_req(2'd3, BASE_A, "R9", 0, 1'b1, BASE_B);
    do_req(2'd2, BASE_A, "R1");
    do_req(2'd3, BASE_A, "R9", 0, 1'b0, '0, 1'b0, 1'b1, BASE_A + 32'd1);

    // R10 replacement and link with concurrent clearing
    do_req(2'd2, BASE_A, "R1");
    do_req(2'd2, BASE_B, "R10");
    do_req(2'd3, BASE_A, "R10");
    do_req(2'd2, BASE_A, "R1");
    do_req(2'd2, BASE_B, "R10");
    do_req(2'd3, BASE_B, "R10");
    do_req(2'd2, BASE_A, "R10", 0, 1'b1, BASE_A + 32'd12);
    do_req(2'd3, BASE_A, "R10");
    do_req(2'd2, BASE_A, "R10", 0, 1'b0, '0, 1'b1);
    do_req(2'd3, BASE_A, "R10");
    do_req(2'd2, BASE_A, "R10", 0, 1'b1, BASE_B);
    do_req(2'd3, BASE_A, "R10");

    // R11 plain traffic to reserved line
    do_req(2'd2, BASE_A, "R1");
    do_req(2'd1, BASE_A + 32'd16, "R11", 1);
    do_req(2'd0, BASE_A, "R11", 2);
    do_req(2'd3, BASE_A, "R11");
    do_req(2'd1, BASE_A, "R11");
    do_req(2'd3, BASE_A, "R11");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule